// File: doc/BRIEF.md
# Row Control Packet Decoder

This block sits behind the receiver of a three-wire row control bus and turns its traffic into command strobes for one DRAM device. The bus carries a bit on every clock edge, and the front end delivers those bits as two three-bit beats per clock cycle: `row_rise_i` holds the even bit time and `row_fall_i` holds the odd one. A packet lasts four cycles, which is eight bit times or 24 bits. The decoder finds where each packet starts from two framing wires, assembles the packet, and checks its device address against a 5-bit device identifier. The framing wires also carry the top address bit and a broadcast code.

A matched packet is either a row activate or a row operation. An activate gives a bank and a 9-bit row. A row operation carries an 11-bit opcode. One opcode can combine a precharge or refresh command with a power-state request in the same packet, so several strobes can pulse together. The block also owns the refresh row counter. A refresh-activate uses that counter as its row address, and the counter advances after the highest bank is refreshed.

All strobes are registered. They pulse for exactly one cycle, in the cycle after the fourth cycle of the packet. The bank and row outputs are updated in that same cycle and hold their value until the next matched packet.

Top module: `rowcmd_decoder`

## Requirements
- R1: In packet cycle k (k = 0..3), bit time 2k is taken from `row_rise_i` and bit time 2k+1 from `row_fall_i`. Wire 2 is the MSB of each beat. Strobes and fields appear in the cycle after packet cycle 3.
- R2: A packet starts only in an idle cycle whose `row_rise_i[2]` or `row_rise_i[1]` is 1. Framing bits are ignored for the next three cycles, and a new packet may start in the first cycle after. A framing pattern on `row_fall_i` alone never starts a packet.
- R3: Device match uses bit time 0, with wire 2 = T, wire 1 = F and wire 0 = A3, and bit time 1 = A2..A0. T,F = 1,1 is broadcast and always matches. 0,1 matches when `dev_id_i` == {0,A3..A0}. 1,0 matches when `dev_id_i` == {1,A3..A0}. An unmatched packet pulses no strobe and leaves `bank_o` and `row_o` unchanged.
- R4: Bank bits are B0,B1,B2 in bit time 2 (wires 2,1,0) and B3,B4 in bit time 3 (wires 2,1). The select bit is bit time 4 wire 0. Select = 1 pulses `act_o` and `attn_o`. It sets `bank_o` to the bank and `row_o` to the row bits, which are bit times 5,6,7 taken MSB first on wires 2,1,0. Bit time 3 wire 0 and bit time 4 wires 2,1 are ignored.
- R5: Select = 0 uses opcode P[10:0] = {bit time 4 wires 2,1; bit times 5,6,7 on wires 2,1,0}. With P[2:0] = 000, P[10:6] = 11000 pulses `pre_o`. P[10:6] = 00011 with P[5:4] = 00 pulses `refa_o`. P[10:6] = 10101 with P[5:4] = 00 pulses `refp_o`. Any other P[10:6] pulses none of these three.
- R6: With P[2:0] = 000, P[5:4] = 01/10/11 pulses `pdn_o`/`nap_o`/`napc_o` and P[3] = 1 pulses `relax_o`. These combine with the R5 strobes in the same cycle.
- R7: With P[3:0] = 0000, a non-zero opcode that is not broadcast pulses `attn_o`. An all-zero opcode pulses nothing. A broadcast row operation never pulses `attn_o`.
- R8: P[10:4] = 0 with P[2:0] = 001 pulses `tcal_o`, and with P[2:0] = 010 pulses `tcen_o`. P[3] has no effect on these two.
- R9: A matched refresh-activate sets `row_o` to the 9-bit refresh counter. The counter resets to 0, advances by one only when the bank is 31, and wraps from 511 to 0.
- R10: After reset all strobes are 0 and `bank_o` and `row_o` are 0.
- R11: Every strobe is high for exactly one cycle per accepted packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dev_id_i | input | 5 | Device identifier of this device |
| row_rise_i | input | 3 | Even bit time of the row bus in this cycle |
| row_fall_i | input | 3 | Odd bit time of the row bus in this cycle |
| act_o | output | 1 | Row activate strobe |
| pre_o | output | 1 | Precharge strobe |
| refa_o | output | 1 | Refresh-activate strobe |
| refp_o | output | 1 | Refresh-precharge strobe |
| pdn_o | output | 1 | Powerdown request strobe |
| nap_o | output | 1 | Nap request strobe |
| napc_o | output | 1 | Conditional nap request strobe |
| attn_o | output | 1 | Attention request strobe |
| relax_o | output | 1 | Relax (standby) request strobe |
| tcal_o | output | 1 | Temperature calibrate strobe |
| tcen_o | output | 1 | Temperature calibrate-enable strobe |
| bank_o | output | 5 | Bank of the last matched packet |
| row_o | output | 9 | Row of the last activate or refresh-activate |

## Verification
A single opcode can pulse a bank command and a power-state request in the same cycle, for example precharge together with conditional nap and relax, or powerdown together with attention. A refresh-activate to bank 31 drives out the counter value while the counter advances at the same edge. The bench sends these combined opcodes, back-to-back refreshes to bank 31 up to the counter wrap, and a new packet framed in the cycle right after a strobe cycle. On every clock it compares all thirteen outputs at once against a behavioural model, so a missing or extra strobe in a combined cycle is reported as a mismatch.

// File: rtl/rowcmd_pkg.sv
package rowcmd_pkg;
  localparam int WIRES  = 3;
  localparam int CYCLES = 4;
  localparam int BEATS  = 2 * CYCLES;
  localparam int DEV_W  = 5;
  localparam int BANK_W = 5;
  localparam int ROW_W  = 9;
  localparam int OP_W   = 11;

  typedef struct packed {
    logic act;
    logic pre;
    logic refa;
    logic refp;
    logic pdn;
    logic nap;
    logic napc;
    logic attn;
    logic relax;
    logic tcal;
    logic tcen;
  } cmd_t;
endpackage

// File: rtl/rowcmd_deframe.sv
module rowcmd_deframe
  import rowcmd_pkg::*;
#(
  parameter int CYC = CYCLES,
  parameter int W   = WIRES
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [W-1:0]             rise_i,
  input  logic [W-1:0]             fall_i,
  output logic                     last_o,
  output logic [2*CYC-1:0][W-1:0]  pkt_o
);
  localparam int HB = 2 * CYC - 2;
  localparam int CW = $clog2(CYC + 1);

  logic [CW-1:0]       left_q;
  logic [HB-1:0][W-1:0] hist_q;
  logic                start;

  // framing is only looked at while no packet is in flight
  assign start = (left_q == '0) && (rise_i[W-1] | rise_i[W-2]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q <= '0;
      hist_q <= '0;
    end else begin
      hist_q <= {hist_q[HB-3:0], rise_i, fall_i};
      if (start)              left_q <= CW'(CYC - 1);
      else if (left_q != '0)  left_q <= left_q - CW'(1);
    end
  end

  assign last_o = (left_q == CW'(1));
  // element 2*CYC-1 is bit time 0
  assign pkt_o  = {hist_q, rise_i, fall_i};
endmodule

// File: rtl/rowcmd_match.sv
module rowcmd_match
  import rowcmd_pkg::*;
#(
  parameter int DW = DEV_W
) (
  input  logic          hi_t_i,
  input  logic          hi_f_i,
  input  logic [DW-2:0] lo_i,
  input  logic [DW-1:0] dev_id_i,
  output logic          hit_o,
  output logic          bcast_o
);
  assign bcast_o = hi_t_i & hi_f_i;
  assign hit_o   = bcast_o | ((hi_t_i ^ hi_f_i) && (dev_id_i == {hi_t_i, lo_i}));
endmodule

// File: rtl/rowcmd_opdec.sv
module rowcmd_opdec
  import rowcmd_pkg::*;
#(
  parameter int OW = OP_W
) (
  input  logic          av_i,
  input  logic          bcast_i,
  input  logic [OW-1:0] op_i,
  output cmd_t          cmd_o
);
  logic rop, z, pwr0;

  assign rop  = ~av_i;
  assign z    = (op_i[2:0] == 3'b000);
  assign pwr0 = (op_i[5:4] == 2'b00);

  always_comb begin
    cmd_o       = '0;
    cmd_o.act   = av_i;
    cmd_o.pre   = rop & z & (op_i[OW-1:6] == 5'b11000);
    cmd_o.refa  = rop & z & pwr0 & (op_i[OW-1:6] == 5'b00011);
    cmd_o.refp  = rop & z & pwr0 & (op_i[OW-1:6] == 5'b10101);
    cmd_o.pdn   = rop & z & (op_i[5:4] == 2'b01);
    cmd_o.nap   = rop & z & (op_i[5:4] == 2'b10);
    cmd_o.napc  = rop & z & (op_i[5:4] == 2'b11);
    cmd_o.relax = rop & z & op_i[3];
    cmd_o.attn  = av_i | (rop & z & ~op_i[3] & (op_i != '0) & ~bcast_i);
    cmd_o.tcal  = rop & (op_i[OW-1:4] == '0) & (op_i[2:0] == 3'b001);
    cmd_o.tcen  = rop & (op_i[OW-1:4] == '0) & (op_i[2:0] == 3'b010);
  end
endmodule

// File: rtl/rowcmd_decoder.sv
module rowcmd_decoder
  import rowcmd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DEV_W-1:0]  dev_id_i,
  input  logic [WIRES-1:0]  row_rise_i,
  input  logic [WIRES-1:0]  row_fall_i,
  output logic              act_o,
  output logic              pre_o,
  output logic              refa_o,
  output logic              refp_o,
  output logic              pdn_o,
  output logic              nap_o,
  output logic              napc_o,
  output logic              attn_o,
  output logic              relax_o,
  output logic              tcal_o,
  output logic              tcen_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [ROW_W-1:0]  row_o
);
  // beat index of bit time t is BEATS-1-t
  localparam int T0 = BEATS - 1;

  logic                         last;
  logic [BEATS-1:0][WIRES-1:0]  pkt;
  logic                         hit, bcast, fire;
  logic [BANK_W-1:0]            bank;
  logic [ROW_W-1:0]             raddr;
  logic [OP_W-1:0]              op;
  cmd_t                         cmd, cmd_q;
  logic [BANK_W-1:0]            bank_q;
  logic [ROW_W-1:0]             row_q, ref_row_q;
  logic                         unused_rsv;

  rowcmd_deframe u_deframe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rise_i (row_rise_i),
    .fall_i (row_fall_i),
    .last_o (last),
    .pkt_o  (pkt)
  );

  rowcmd_match u_match (
    .hi_t_i   (pkt[T0][2]),
    .hi_f_i   (pkt[T0][1]),
    .lo_i     ({pkt[T0][0], pkt[T0-1]}),
    .dev_id_i (dev_id_i),
    .hit_o    (hit),
    .bcast_o  (bcast)
  );

  assign bank  = {pkt[T0-3][1], pkt[T0-3][2], pkt[T0-2][0], pkt[T0-2][1], pkt[T0-2][2]};
  assign raddr = {pkt[T0-5], pkt[T0-6], pkt[T0-7]};
  assign op    = {pkt[T0-4][2], pkt[T0-4][1], raddr};
  assign unused_rsv = ^{pkt[T0-3][0]};

  rowcmd_opdec u_opdec (
    .av_i    (pkt[T0-4][0]),
    .bcast_i (bcast),
    .op_i    (op),
    .cmd_o   (cmd)
  );

  assign fire = last & hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q     <= '0;
      bank_q    <= '0;
      row_q     <= '0;
      ref_row_q <= '0;
    end else begin
      cmd_q <= fire ? cmd : '0;
      if (fire) begin
        bank_q <= bank;
        if (cmd.act)       row_q <= raddr;
        else if (cmd.refa) row_q <= ref_row_q;
        if (cmd.refa && (bank == '1)) ref_row_q <= ref_row_q + ROW_W'(1);
      end
    end
  end

  assign act_o   = cmd_q.act;
  assign pre_o   = cmd_q.pre;
  assign refa_o  = cmd_q.refa;
  assign refp_o  = cmd_q.refp;
  assign pdn_o   = cmd_q.pdn;
  assign nap_o   = cmd_q.nap;
  assign napc_o  = cmd_q.napc;
  assign attn_o  = cmd_q.attn;
  assign relax_o = cmd_q.relax;
  assign tcal_o  = cmd_q.tcal;
  assign tcen_o  = cmd_q.tcen;
  assign bank_o  = bank_q;
  assign row_o   = row_q;
endmodule

// File: rtl/rowcmd_decoder_chk.sv
module rowcmd_decoder_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       act_i,
  input logic       pre_i,
  input logic       refa_i,
  input logic       refp_i,
  input logic       pdn_i,
  input logic       nap_i,
  input logic       napc_i,
  input logic       attn_i,
  input logic       relax_i,
  input logic       tcal_i,
  input logic       tcen_i,
  input logic [4:0] bank_i,
  input logic [8:0] ref_row_i
);
  logic any_strobe;
  assign any_strobe = act_i | pre_i | refa_i | refp_i | pdn_i | nap_i | napc_i |
                      attn_i | relax_i | tcal_i | tcen_i;

  AST_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_strobe |=> !any_strobe); // R11

  AST_ACT_ATTN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i |-> attn_i); // R4

  AST_ROW_CMD_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({act_i, pre_i, refa_i, refp_i})); // R5

  AST_PWR_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({pdn_i, nap_i, napc_i})); // R6

  AST_TCAL_ALONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tcal_i | tcen_i) |-> !(act_i | pre_i | refa_i | refp_i | pdn_i | nap_i |
                            napc_i | relax_i | attn_i)); // R8

  AST_REF_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (refa_i && bank_i == 5'd31) |-> (ref_row_i == $past(ref_row_i) + 9'd1)); // R9

  AST_REF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(refa_i && bank_i == 5'd31) |-> $stable(ref_row_i)); // R9
endmodule

bind rowcmd_decoder rowcmd_decoder_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .act_i     (act_o),
  .pre_i     (pre_o),
  .refa_i    (refa_o),
  .refp_i    (refp_o),
  .pdn_i     (pdn_o),
  .nap_i     (nap_o),
  .napc_i    (napc_o),
  .attn_i    (attn_o),
  .relax_i   (relax_o),
  .tcal_i    (tcal_o),
  .tcen_i    (tcen_o),
  .bank_i    (bank_o),
  .ref_row_i (ref_row_q)
);

// File: tb/rowcmd_decoder_tb.sv
module rowcmd_decoder_tb;
  logic       clk;
  logic       rst_n;
  logic [4:0] dev_id;
  logic [2:0] rise, fall;
  logic act, pre, refa, refp, pdn, nap, napc, attn, relax, tcal, tcen;
  logic [4:0] bank;
  logic [8:0] row;

  rowcmd_decoder u_dut (
    .clk_i(clk), .rst_ni(rst_n), .dev_id_i(dev_id),
    .row_rise_i(rise), .row_fall_i(fall),
    .act_o(act), .pre_o(pre), .refa_o(refa), .refp_o(refp),
    .pdn_o(pdn), .nap_o(nap), .napc_o(napc), .attn_o(attn),
    .relax_o(relax), .tcal_o(tcal), .tcen_o(tcen),
    .bank_o(bank), .row_o(row)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int    n_chk = 0;
  int    n_bad = 0;
  bit    finished = 0;
  string cur_req = "R10";

  // reference model state
  bit [10:0] e_cmd;   // act,pre,refa,refp,pdn,nap,napc,attn,relax,tcal,tcen
  bit [4:0]  e_bank;
  bit [8:0]  e_row;
  int        m_ref  = 0;
  int        m_left = 0;
  bit [2:0]  m_q[$];

  function automatic void model_decode();
    bit [2:0]  b[8];
    bit        t, f, av, hit, bc;
    bit [3:0]  lo;
    bit [4:0]  bk;
    bit [10:0] op;
    for (int i = 0; i < 8; i++) b[i] = m_q[i];
    t  = b[0][2];
    f  = b[0][1];
    lo = {b[0][0], b[1]};
    bk = {b[3][1], b[3][2], b[2][0], b[2][1], b[2][2]};
    av = b[4][0];
    op = {b[4][2], b[4][1], b[5], b[6], b[7]};
    bc  = t && f;
    hit = bc || (t != f && dev_id == {t, lo});
    if (!hit) return;
    e_bank = bk;
    if (av) begin
      e_cmd[10] = 1; e_cmd[3] = 1;
      e_row = {b[5], b[6], b[7]};
      return;
    end
    if (op[2:0] == 0) begin
      case (op[10:6])
        5'b11000: e_cmd[9] = 1;
        5'b00011: if (op[5:4] == 0) e_cmd[8] = 1;
        5'b10101: if (op[5:4] == 0) e_cmd[7] = 1;
        default: ;
      endcase
      case (op[5:4])
        2'd1: e_cmd[6] = 1;
        2'd2: e_cmd[5] = 1;
        2'd3: e_cmd[4] = 1;
        default: ;
      endcase
      if (op[3]) e_cmd[2] = 1;
      else if (op != 0 && !bc) e_cmd[3] = 1;
    end
    if (op[10:4] == 0 && op[2:0] == 3'd1) e_cmd[1] = 1;
    if (op[10:4] == 0 && op[2:0] == 3'd2) e_cmd[0] = 1;
    if (e_cmd[8]) begin
      e_row = 9'(m_ref);
      if (bk == 5'd31) m_ref = (m_ref + 1) % 512;
    end
  endfunction

  function automatic void model_step(bit [2:0] r, bit [2:0] fl);
    e_cmd = '0;
    if (m_left == 0) begin
      if (r[2] | r[1]) begin
        m_q.delete();
        m_q.push_back(r);
        m_q.push_back(fl);
        m_left = 3;
      end
    end else begin
      m_q.push_back(r);
      m_q.push_back(fl);
      m_left--;
      if (m_left == 0) model_decode();
    end
  endfunction

  task automatic compare();
    bit [24:0] got, exp;
    got = {act, pre, refa, refp, pdn, nap, napc, attn, relax, tcal, tcen, bank, row};
    exp = {e_cmd, e_bank, e_row};
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", cur_req, got, exp);
    end
  endtask

  task automatic step(input bit [2:0] r, input bit [2:0] fl);
    @(negedge clk);
    compare();
    rise = r;
    fall = fl;
    model_step(r, fl);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(3'b000, 3'b000);
  endtask

  // x[8:0] = row for activate; x[10:0] = opcode for row operation
  task automatic send(input bit t, input bit f, input bit [3:0] lo, input bit [4:0] bk,
                      input bit av, input bit [10:0] x);
    bit [2:0] bt[8];
    bt[0] = {t, f, lo[3]};
    bt[1] = lo[2:0];
    bt[2] = {bk[0], bk[1], bk[2]};
    bt[3] = {bk[3], bk[4], 1'b1};
    bt[4] = {x[10], x[9], av};
    bt[5] = x[8:6];
    bt[6] = x[5:3];
    bt[7] = x[2:0];
    for (int c = 0; c < 4; c++) step(bt[2*c], bt[2*c+1]);
  endtask

  // this device: id 10110 -> T,F = 1,0 with low bits 0110
  task automatic rop(input bit [4:0] bk, input bit [10:0] op);
    send(1'b1, 1'b0, 4'b0110, bk, 1'b0, op);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n  = 1'b0;
    dev_id = 5'b10110;
    rise   = '0;
    fall   = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    cur_req = "R10"; idle(3);

    cur_req = "R1";  send(1'b1, 1'b0, 4'b0110, 5'd19, 1'b1, 11'h6A5); idle(2);
    cur_req = "R4";  send(1'b1, 1'b0, 4'b0110, 5'd6, 1'b1, 11'h05A);
    cur_req = "R11"; idle(3);

    cur_req = "R3";
    send(1'b0, 1'b1, 4'b0110, 5'd2, 1'b1, 11'h011); idle(1);     // {0,0110} mismatch
    send(1'b1, 1'b1, 4'b0000, 5'd9, 1'b0, 11'b11000_00_0_000);  // broadcast precharge
    idle(1);
    dev_id = 5'b01001;
    send(1'b0, 1'b1, 4'b1001, 5'd12, 1'b1, 11'h133);
    send(1'b1, 1'b0, 4'b1001, 5'd13, 1'b1, 11'h044);             // {1,1001} mismatch
    idle(1);
    dev_id = 5'b10110;

    cur_req = "R5";
    rop(5'd3,  11'b11000_00_0_000);
    rop(5'd4,  11'b10101_00_0_000);
    rop(5'd7,  11'b01110_00_0_000);   // reserved group, bank still updates
    rop(5'd8,  11'b11000_00_0_011);   // low bits non-zero: nothing
    idle(1);

    cur_req = "R6";
    rop(5'd10, 11'b11000_11_1_000);   // precharge + conditional nap + relax
    rop(5'd11, 11'b00000_01_0_000);   // powerdown + attention
    rop(5'd1,  11'b00000_10_1_000);   // nap + relax
    idle(1);

    cur_req = "R7";
    rop(5'd5,  11'b00000_00_0_000);
    send(1'b1, 1'b1, 4'b0000, 5'd5, 1'b0, 11'b00000_01_0_000);
    rop(5'd20, 11'b01000_00_0_000);
    idle(1);

    cur_req = "R8";
    rop(5'd0,  11'b00000_00_0_001);
    rop(5'd0,  11'b00000_00_1_010);
    rop(5'd0,  11'b00000_01_0_001);   // upper bits set: nothing
    idle(1);

    cur_req = "R9";
    rop(5'd5,  11'b00011_00_0_000);
    rop(5'd31, 11'b00011_00_0_000);
    rop(5'd31, 11'b00011_00_0_000);
    rop(5'd0,  11'b00011_00_0_000);
    rop(5'd31, 11'b10101_00_0_000);   // refresh-precharge does not advance
    rop(5'd31, 11'b00011_00_0_000);
    while (m_ref != 511) rop(5'd31, 11'b00011_00_1_000);
    rop(5'd31, 11'b00011_00_0_000);   // drives 511, wraps to 0
    rop(5'd31, 11'b00011_00_0_000);
    idle(1);

    cur_req = "R2";
    step(3'b000, 3'b110); step(3'b000, 3'b010); idle(1);         // fall-only framing
    rop(5'd3, 11'b11000_00_0_000);                               // inner beats carry framing-like bits
    send(1'b1, 1'b0, 4'b0110, 5'd27, 1'b1, 11'h1FF);             // back to back
    rop(5'd31, 11'b00000_00_1_000);
    idle(4);

    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule